// File: doc/BRIEF.md
# Opcode-Dependent Stall Sequencer

This block produces the freeze signal for the front of a pipeline whose execute stage is shared by several operation kinds that take different numbers of clocks. The decoder presents one-bit class flags for the instruction sitting in the execute stage: multiply, divide, add and subtract. A multiply needs one extra clock in the stage and a divide needs two. Add and subtract finish in a single clock. While the freeze output is high, the earlier stages hold, so the instruction and its flags stay in place.

The controller is a three-state machine with one flip-flop per state: an idle state, a state that holds for one more clock, and a state that holds for two more clocks. The freeze output is a Mealy output. In the idle state it rises in the same cycle that a multiply or divide flag appears. It stays high in the two-more state and is low in the one-more state, so that the held instruction can finish. An instruction therefore occupies the stage for its extra-cycle count plus one clock. The freeze output is high during the first of those clocks, and during the second as well for a divide.

Top module: `exec_stall_top`

## Requirements
- R1: The active-low reset is asynchronous. It puts the machine in the idle state at once, even in the middle of a stall, and the freeze output is low while reset is held with no flag raised. After release, a multiply flag is handled as it would be from idle.
- R2: A multiply flag seen in the idle state gives a freeze output that is high for exactly one clock and then low for one clock. The next instruction is accepted in the clock after that.
- R3: A divide flag seen in the idle state gives a freeze output that is high for exactly two clocks and then low for one clock. The next instruction is accepted in the clock after that.
- R4: Add or subtract flags never raise the freeze output, and the machine stays idle. Back-to-back add and subtract instructions each take one clock. At most one of the four flags is high in any cycle.
- R5: In the idle state, the freeze output follows the multiply and divide flags combinationally, within the same clock and without waiting for an edge.
- R6: Once the machine has left idle, its path through the two-more state, then the one-more state, then idle is fixed. Flag values seen in the two-more or one-more state change neither the path nor the freeze output.
- R7: Divide, multiply, subtract, multiply and add, issued back to back with no idle gaps, give a freeze pattern of 1,1,0 / 1,0 / 0 / 1,0 / 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| isMul | input | 1 | Instruction in execute is a multiply |
| isDiv | input | 1 | Instruction in execute is a divide |
| isAdd | input | 1 | Instruction in execute is an add |
| isSub | input | 1 | Instruction in execute is a subtract |
| stall | output | 1 | Freeze request to the earlier pipeline stages |

## Verification
Some properties are checked on every cycle. The state register must always hold exactly one set bit. A divide taken from idle must land in the two-more state. The two-more state must always step to the one-more state, and the one-more state must always step to idle. The freeze output must be low in the one-more state and must drop one clock after a multiply is taken from idle. The class flags must never have more than one bit set.

Other behaviours only the bench scenarios can show. These are the exact freeze counts seen at the port for mixed back-to-back instruction streams, the same-cycle Mealy response when a flag changes between edges, the fact that flags arriving in a stalled state are ignored, and the effect of pulling reset in the middle of a divide.

// File: rtl/exec_stall_pkg.sv
package exec_stall_pkg;
  localparam int NUM_STATES = 3;
  localparam int IDX_IDLE   = 0;
  localparam int IDX_ONE    = 1;
  localparam int IDX_TWO    = 2;
  localparam logic [NUM_STATES-1:0] RESET_VEC = NUM_STATES'(1) << IDX_IDLE;

  // Extra-cycle demand of the instruction sitting in execute
  typedef struct packed {
    logic needOne;
    logic needTwo;
  } opNeed_t;

  // State strobes from control to the output logic
  typedef struct packed {
    logic atIdle;
    logic atOne;
    logic atTwo;
  } ctrlStrobe_t;
endpackage

// File: rtl/exec_stall_decode.sv
module exec_stall_decode
  import exec_stall_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    isMul,
  input  logic    isDiv,
  input  logic    isAdd,
  input  logic    isSub,
  output opNeed_t need
);
  // Add and subtract carry no extra-cycle demand
  always_comb begin
    need.needOne = isMul;
    need.needTwo = isDiv;
  end

  AST_SINGLE_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isMul, isDiv, isAdd, isSub})); // R4
endmodule

// File: rtl/exec_stall_ctrl.sv
module exec_stall_ctrl
  import exec_stall_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  opNeed_t     need,
  output ctrlStrobe_t strobe
);
  logic [NUM_STATES-1:0] stateQ;
  logic [NUM_STATES-1:0] stateD;
  logic                  anyNeed;

  assign anyNeed = need.needOne | need.needTwo;

  // One equation per state flip-flop
  always_comb begin
    stateD           = '0;
    stateD[IDX_TWO]  = stateQ[IDX_IDLE] & need.needTwo;
    stateD[IDX_ONE]  = (stateQ[IDX_IDLE] & need.needOne & ~need.needTwo)
                     | stateQ[IDX_TWO];
    stateD[IDX_IDLE] = (stateQ[IDX_IDLE] & ~anyNeed) | stateQ[IDX_ONE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= RESET_VEC;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.atIdle = stateQ[IDX_IDLE];
    strobe.atOne  = stateQ[IDX_ONE];
    strobe.atTwo  = stateQ[IDX_TWO];
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(stateQ)); // R1
  AST_DIV_ENTERS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    stateQ[IDX_IDLE] && need.needTwo |=> stateQ[IDX_TWO]); // R3
  AST_TWO_THEN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ[IDX_TWO] |=> stateQ[IDX_ONE]); // R6
  AST_ONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ[IDX_ONE] |=> stateQ[IDX_IDLE]); // R6
endmodule

// File: rtl/exec_stall_out.sv
module exec_stall_out
  import exec_stall_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  opNeed_t     need,
  output logic        stall
);
  // Mealy term in idle, Moore term in the two-more state
  assign stall = (strobe.atIdle & (need.needOne | need.needTwo)) | strobe.atTwo;

  AST_ONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.atOne |-> !stall); // R2
  AST_MUL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stall && strobe.atIdle && need.needOne && !need.needTwo |=> !stall); // R2
endmodule

// File: rtl/exec_stall_top.sv
module exec_stall_top
  import exec_stall_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic isMul,
  input  logic isDiv,
  input  logic isAdd,
  input  logic isSub,
  output logic stall
);
  opNeed_t     need;
  ctrlStrobe_t strobe;

  exec_stall_decode u_decode (
    .clk(clk), .rstN(rstN), .isMul(isMul), .isDiv(isDiv),
    .isAdd(isAdd), .isSub(isSub), .need(need)
  );

  exec_stall_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .need(need), .strobe(strobe)
  );

  exec_stall_out u_out (
    .clk(clk), .rstN(rstN), .strobe(strobe), .need(need), .stall(stall)
  );
endmodule

// File: tb/sim_exec_stall_top.sv
module sim_exec_stall_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VECS   = 24;

  // flags packed as {mul, div, add, sub}
  typedef struct packed {
    logic [3:0] flags;
    logic       expStall;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NUM_VECS] = '{
    // R7: D M S M A back to back
    '{4'b0100, 1'b1, 4'd7}, '{4'b0100, 1'b1, 4'd7}, '{4'b0100, 1'b0, 4'd7},
    '{4'b1000, 1'b1, 4'd7}, '{4'b1000, 1'b0, 4'd7}, '{4'b0001, 1'b0, 4'd7},
    '{4'b1000, 1'b1, 4'd7}, '{4'b1000, 1'b0, 4'd7}, '{4'b0010, 1'b0, 4'd7},
    '{4'b0000, 1'b0, 4'd7},
    // R4: add/sub stream
    '{4'b0010, 1'b0, 4'd4}, '{4'b0001, 1'b0, 4'd4}, '{4'b0010, 1'b0, 4'd4},
    // R2: two multiplies
    '{4'b1000, 1'b1, 4'd2}, '{4'b1000, 1'b0, 4'd2},
    '{4'b1000, 1'b1, 4'd2}, '{4'b1000, 1'b0, 4'd2},
    // R3: two divides
    '{4'b0100, 1'b1, 4'd3}, '{4'b0100, 1'b1, 4'd3}, '{4'b0100, 1'b0, 4'd3},
    '{4'b0100, 1'b1, 4'd3}, '{4'b0100, 1'b1, 4'd3}, '{4'b0100, 1'b0, 4'd3},
    '{4'b0000, 1'b0, 4'd3}
  };

  logic clk = 1'b0;
  logic rstN;
  logic isMul, isDiv, isAdd, isSub;
  logic stall;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_stall_top u0 (
    .clk(clk), .rstN(rstN), .isMul(isMul), .isDiv(isDiv),
    .isAdd(isAdd), .isSub(isSub), .stall(stall)
  );

  task automatic setFlags(input logic [3:0] f);
    {isMul, isDiv, isAdd, isSub} = f;
  endtask

  task automatic check(input logic exp, input string tag);
    nChecks++;
    if (stall !== exp) begin
      nFails++;
      $display("FAIL %s: stall=%b expected=%b at %0t", tag, stall, exp, $time);
    end
  endtask

  task automatic stepCheck(input logic [3:0] f, input logic exp, input string tag);
    @(negedge clk);
    setFlags(f);
    #1 check(exp, tag);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    setFlags(4'b0000);
    repeat (2) @(negedge clk);
    #1 check(1'b0, "R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #1 check(1'b0, "R1 after release");

    for (int i = 0; i < NUM_VECS; i++) begin
      @(negedge clk);
      setFlags(VECS[i].flags);
      #1;
      nChecks++;
      if (stall !== VECS[i].expStall) begin
        nFails++;
        $display("FAIL R%0d vector %0d: stall=%b expected=%b",
                 VECS[i].req, i, stall, VECS[i].expStall);
      end
    end

    // R5: Mealy response between edges
    stepCheck(4'b0000, 1'b0, "R5 idle quiet");
    #(CLK_PERIOD/4);
    setFlags(4'b0100);
    #1 check(1'b1, "R5 same-cycle rise");
    stepCheck(4'b0100, 1'b1, "R5 divide second clock");
    stepCheck(4'b0100, 1'b0, "R5 divide release");
    stepCheck(4'b0000, 1'b0, "R5 back to idle");

    // R6: flags seen in stalled states are ignored
    stepCheck(4'b0100, 1'b1, "R6 divide taken");
    stepCheck(4'b0010, 1'b1, "R6 add ignored in two-more");
    stepCheck(4'b0100, 1'b0, "R6 divide ignored in one-more");
    stepCheck(4'b0000, 1'b0, "R6 idle reached");
    stepCheck(4'b1000, 1'b1, "R6 idle responds again");
    stepCheck(4'b0000, 1'b0, "R6 one-more after multiply");

    // R1: asynchronous reset during a divide
    stepCheck(4'b0100, 1'b1, "R1 divide before reset");
    stepCheck(4'b0100, 1'b1, "R1 divide held");
    #(CLK_PERIOD/4);
    setFlags(4'b0000);
    rstN = 1'b0;
    #1 check(1'b0, "R1 async reset mid-stall");
    @(negedge clk);
    rstN = 1'b1;
    setFlags(4'b1000);
    #1 check(1'b1, "R1 idle after reset");
    stepCheck(4'b1000, 1'b0, "R1 multiply release after reset");
    stepCheck(4'b0000, 1'b0, "R1 quiet");

    finishRun();
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end
endmodule